// File: doc/BRIEF.md
# Bit-Serial Half-Scaling Adder

This block adds two streams of B-bit two's-complement fractions that arrive one bit per cycle, least significant bit first. Each result is the exact sum halved, rounded toward minus infinity, so the result always fits in B bits. The operands need no pre-shift, so no operand precision is lost before the add. A single full-adder cell does the work, one bit position per cycle. A carry register carries each position into the next. In the cycle that handles the sign position, the carry into the majority term is inverted, so the majority output gives the sign of the halved result. An output multiplexer then places that sign in the stream. It does so in the cycle that holds the next word's least significant sum, and that sum bit is dropped.

A start pulse, high with the first bit of a word, aligns a modulo-B phase counter. The counter then runs freely, so words may follow back to back with or without further start pulses. Results leave serially, LSB first, with a marker on the first bit of each result word.

Top module: `bsadd_oscale`

## Requirements
- R1: For every operand pair, including both extremes of the range, the B-bit result word equals floor((a+b)/2), read as two's complement. It never wraps.
- R2: Operand bits are taken one per cycle, LSB first. A word occupies exactly B cycles, and words may follow one another with no idle cycle between them.
- R3: A start pulse marks the cycle of a word's LSB and realigns the phase counter to it. Without further pulses the counter wraps every B cycles, so each later B-cycle slot is treated as a new word.
- R4: The result's most significant bit is the majority of the two operand sign bits and the inverted carry that enters the sign position.
- R5: Result bit i of a word appears on res_o during the cycle that is 3+i cycles after the cycle in which the word's start pulse (or its LSB slot) was sampled. This is two cycles after operand bit i+1.
- R6: mark_o is high for exactly one cycle per result word, in the cycle that carries result bit 0.
- R7: Reset clears the phase counter and the carry. res_o and mark_o stay 0 from reset until the first result bit of the first word after a start pulse. Operand bits presented before any start pulse have no effect on either output.
- R8: In each word's LSB cycle the carry into the adder is forced to 0, so a result never depends on the previous word. In that same cycle the output stage emits the previous word's sign and discards the new word's LSB sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | High in the cycle that carries a word's LSB |
| a_i | input | 1 | Serial operand A, LSB first |
| b_i | input | 1 | Serial operand B, LSB first |
| res_o | output | 1 | Serial halved sum, LSB first |
| mark_o | output | 1 | High with bit 0 of each result word |

## Verification
In a word's LSB cycle, two things happen at once. The carry is cleared for the new word, and the previous word's sign is put on the output in place of the new LSB sum. The bench provokes this collision by streaming words back to back with no gaps. It pairs operands that leave a live carry out of the sign position, such as both operands at the negative extreme, with a following word whose result is sensitive to a stale carry. A wrong outcome in either function shows up as a miscompare of the deserialised word against floor((a+b)/2), or as a marker that is out of place. A second stream sends a single start pulse, so the same collision is also judged on slots that follow only the counter's wrap.

// File: rtl/bso_pkg.sv
package bso_pkg;

    typedef struct packed {
        logic live;   // counter has been aligned by a start pulse
        logic lsb;    // current bit position is a word's LSB
        logic sgn;    // current bit position is a word's sign bit
        logic first;  // position whose sum becomes result bit 0
    } bso_ctl_t;

    function automatic logic fa_par(input logic x, input logic y, input logic z);
        return x ^ y ^ z;
    endfunction

    function automatic logic fa_maj(input logic x, input logic y, input logic z);
        return (x & y) | (y & z) | (x & z);
    endfunction

endpackage

// File: rtl/bso_seq.sv
module bso_seq
    import bso_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic     clk_i,
    input  logic     rst_i,
    input  logic     start_i,
    output bso_ctl_t ctl_o
);
    localparam int PW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
    localparam logic [PW-1:0] LAST = PW'(WIDTH - 1);
    localparam logic [PW-1:0] ONE  = PW'(1);

    logic [PW-1:0] phase_q;
    logic          live_q;

    // Phase register aligns with the operand register stage of bso_core.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            phase_q <= '0;
            live_q  <= 1'b0;
        end else if (start_i) begin
            phase_q <= '0;
            live_q  <= 1'b1;
        end else if (live_q) begin
            phase_q <= (phase_q == LAST) ? '0 : phase_q + ONE;
        end
    end

    always_comb begin
        ctl_o.live  = live_q;
        ctl_o.lsb   = live_q && (phase_q == '0);
        ctl_o.sgn   = live_q && (phase_q == LAST);
        ctl_o.first = live_q && (phase_q == ONE);
    end

endmodule

// File: rtl/bso_core.sv
module bso_core
    import bso_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_i,
    input  logic     a_i,
    input  logic     b_i,
    input  bso_ctl_t ctl_i,
    output logic     a_q_o,
    output logic     b_q_o,
    output logic     sum_o,
    output logic     carry_o
);
    logic a_q, b_q, c_q;
    logic cin_gated;
    logic maj_in;
    logic maj_out;

    always_comb begin
        // carry clear at a word's LSB position
        cin_gated = ctl_i.lsb ? 1'b0 : c_q;
        // conditional inverter ahead of the majority term at the sign position
        maj_in    = cin_gated ^ ctl_i.sgn;
        sum_o     = fa_par(a_q, b_q, cin_gated);
        maj_out   = fa_maj(a_q, b_q, maj_in);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            a_q <= 1'b0;
            b_q <= 1'b0;
            c_q <= 1'b0;
        end else begin
            a_q <= a_i;
            b_q <= b_i;
            c_q <= maj_out;
        end
    end

    assign a_q_o   = a_q;
    assign b_q_o   = b_q;
    assign carry_o = c_q;

endmodule

// File: rtl/bso_out.sv
module bso_out
    import bso_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_i,
    input  bso_ctl_t ctl_i,
    input  logic     sum_i,
    input  logic     carry_i,
    output logic     res_o,
    output logic     mark_o
);
    logic seen_q, seen_d;
    logic res_q, mark_q;
    logic bit_sel;

    always_comb begin
        // At a word's LSB the held sign of the previous word replaces the sum.
        bit_sel = ctl_i.lsb ? carry_i : sum_i;
        seen_d  = seen_q | ctl_i.first;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            seen_q <= 1'b0;
            res_q  <= 1'b0;
            mark_q <= 1'b0;
        end else begin
            seen_q <= seen_d;
            res_q  <= seen_d ? bit_sel : 1'b0;
            mark_q <= ctl_i.first;
        end
    end

    assign res_o  = res_q;
    assign mark_o = mark_q;

endmodule

// File: rtl/bsadd_oscale.sv
module bsadd_oscale
    import bso_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic start_i,
    input  logic a_i,
    input  logic b_i,
    output logic res_o,
    output logic mark_o
);
    bso_ctl_t ctl;
    logic     a_q, b_q, sum, carry;

    bso_seq #(.WIDTH(WIDTH)) u_seq (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .start_i (start_i),
        .ctl_o   (ctl)
    );

    bso_core u_core (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .a_i     (a_i),
        .b_i     (b_i),
        .ctl_i   (ctl),
        .a_q_o   (a_q),
        .b_q_o   (b_q),
        .sum_o   (sum),
        .carry_o (carry)
    );

    bso_out u_out (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .ctl_i   (ctl),
        .sum_i   (sum),
        .carry_i (carry),
        .res_o   (res_o),
        .mark_o  (mark_o)
    );

endmodule

// File: rtl/bso_check.sv
module bso_check (
    input logic clk_i,
    input logic rst_i,
    input logic start_i,
    input logic live_i,
    input logic lsb_i,
    input logic sgn_i,
    input logic first_i,
    input logic a_q_i,
    input logic b_q_i,
    input logic carry_i,
    input logic res_o,
    input logic mark_o
);
    // R3: a start pulse puts the next cycle at a word's LSB
    a_r3_start_resync: assert property (@(posedge clk_i) disable iff (rst_i)
        start_i |=> (live_i && lsb_i));

    // R2: the sign position is followed by the next word's LSB
    a_r2_modulo_wrap: assert property (@(posedge clk_i) disable iff (rst_i)
        (sgn_i && !start_i) |=> lsb_i);

    // R6: the marker follows the position that yields result bit 0
    a_r6_mark_first: assert property (@(posedge clk_i) disable iff (rst_i)
        first_i |=> mark_o);

    // R7: nothing leaves the block before alignment
    a_r7_quiet_mark: assert property (@(posedge clk_i) disable iff (rst_i)
        !live_i |=> !mark_o);

    a_r7_quiet_res: assert property (@(posedge clk_i) disable iff (rst_i)
        !live_i |=> !res_o);

    // R4: with equal operand signs, the result sign equals that sign
    a_r4_sign_equal: assert property (@(posedge clk_i) disable iff (rst_i)
        (sgn_i && (a_q_i == b_q_i)) |=> (carry_i == $past(a_q_i)));

endmodule

bind bsadd_oscale bso_check u_chk (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .start_i (start_i),
    .live_i  (ctl.live),
    .lsb_i   (ctl.lsb),
    .sgn_i   (ctl.sgn),
    .first_i (ctl.first),
    .a_q_i   (a_q),
    .b_q_i   (b_q),
    .carry_i (carry),
    .res_o   (res_o),
    .mark_o  (mark_o)
);

// File: tb/sim_bsadd_oscale.sv
module sim_bsadd_oscale;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_i = 1'b1;
    logic start_i = 1'b0;
    logic a_i = 1'b0;
    logic b_i = 1'b0;
    logic res_o, mark_o;

    int   n_chk = 0;
    int   n_bad = 0;
    int   cyc = 0;
    string req_tag = "R1 R4 R8";

    logic [W-1:0] exp_v[$];
    int           exp_t[$];
    logic         collecting = 1'b0;
    int           idx = 0;
    logic [W-1:0] got;

    always #2.5 clk = ~clk;   // 200 MHz
    always @(posedge clk) cyc <= cyc + 1;

    bsadd_oscale #(.WIDTH(W)) u0 (
        .clk_i(clk), .rst_i(rst_i), .start_i(start_i),
        .a_i(a_i), .b_i(b_i), .res_o(res_o), .mark_o(mark_o)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [W-1:0] half_sum(input logic [W-1:0] a, input logic [W-1:0] b);
        int sa, sb, s;
        sa = $signed(a);
        sb = $signed(b);
        s  = (sa + sb) >>> 1;
        return s[W-1:0];
    endfunction

    // R2: one bit per cycle, LSB first, B cycles per word
    task automatic send(input logic [W-1:0] a, input logic [W-1:0] b, input bit st);
        for (int i = 0; i < W; i++) begin
            @(negedge clk);
            start_i = st && (i == 0);
            a_i = a[i];
            b_i = b[i];
            if (i == 0) begin
                exp_v.push_back(half_sum(a, b));
                exp_t.push_back(cyc + 3);
            end
        end
    endtask

    // Deserialiser and comparator (R1 R5 R6)
    always @(negedge clk) begin
        if (mark_o) begin
            if (collecting)
                chk(1'b0, "R6 marker inside word", idx, W);
            if (exp_t.size() != 0) begin
                chk(cyc == exp_t[0], "R5 R6 marker cycle", cyc, exp_t[0]);
                void'(exp_t.pop_front());
                collecting = 1'b1;
                idx = 0;
            end else begin
                collecting = 1'b0;
            end
        end
        if (collecting) begin
            got[idx] = res_o;
            idx++;
            if (idx == W) begin
                collecting = 1'b0;
                if (exp_v.size() != 0) begin
                    chk(got == exp_v[0], req_tag, got, exp_v[0]);
                    void'(exp_v.pop_front());
                end
            end
        end
    end

    task automatic finish_up;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R2 watchdog expired actual=%0d expected=%0d", cyc, 0);
        finish_up();
    end

    task automatic drain;
        while (exp_v.size() != 0) begin
            @(negedge clk);
            start_i = 1'b0;
            a_i = 1'b0;
            b_i = 1'b0;
        end
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        chk(res_o == 1'b0, "R7 reset res", res_o, 0);
        chk(mark_o == 1'b0, "R7 reset mark", mark_o, 0);
        rst_i = 1'b0;

        // R7: serial bits before any start pulse are ignored
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(res_o == 1'b0 && mark_o == 1'b0, "R7 pre-start quiet", {res_o, mark_o}, 0);
            a_i = $urandom_range(1);
            b_i = $urandom_range(1);
        end

        // Directed corners, back to back: R1 R4 R8
        req_tag = "R1 R4 R8";
        send(8'h7F, 8'h7F, 1);
        send(8'h80, 8'h80, 1);
        send(8'h01, 8'h00, 1);
        send(8'h80, 8'h7F, 1);
        send(8'hFF, 8'hFF, 1);
        send(8'hFF, 8'h00, 1);
        send(8'h80, 8'h80, 1);
        send(8'h00, 8'h00, 1);
        send(8'h01, 8'h01, 1);
        send(8'h7F, 8'h01, 1);
        send(8'hC0, 8'h40, 1);
        for (int k = 0; k < 150; k++)
            send(W'($urandom), W'($urandom), 1);
        send('0, '0, 0);
        send('0, '0, 0);
        drain();

        // R7: reset mid-run returns outputs to 0
        @(negedge clk);
        rst_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(res_o == 1'b0 && mark_o == 1'b0, "R7 reset again", {res_o, mark_o}, 0);
        rst_i = 1'b0;

        // R3: single start, later words aligned only by the counter wrap
        req_tag = "R1 R3";
        send(8'h80, 8'h80, 1);
        send(8'h7F, 8'h7F, 0);
        send(8'hFF, 8'h01, 0);
        for (int k = 0; k < 40; k++)
            send(W'($urandom), W'($urandom), 0);
        send('0, '0, 0);
        drain();
        repeat (2 * W) @(negedge clk);
        chk(exp_t.size() == 0, "R6 all markers seen", exp_t.size(), 0);
        finish_up();
    end

endmodule